// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block is the read side of a one-time-programmable memory that holds a configuration bitstream. It shifts the bitstream out one bit per clock. A consumer such as a loading FPGA supplies the clock. The block has an active-low chip enable. It also has one control pin that serves as both reset and output enable, and a build parameter sets that pin's polarity. The stored image is built at elaboration time from a seed parameter. The block stands in for a device that was programmed once.

The serial data bit has its own drive-enable output, which replaces a real tri-state pin. There is also an active-low cascade output. When the last stored bit has been read, the block stops driving the shared data line and pulls its cascade output low. That output feeds the chip enable of the next device in a chain, so several devices read out as one continuous stream. If reset is not applied, the address counter keeps its value between reads. A later read then continues from the point where the previous one stopped.

Top module: `serial_cfg_rom`

## Requirements
- R1: With `RST_HIGH`=1, reset is active while `rst_oe` is 1. With `RST_HIGH`=0, reset is active while `rst_oe` is 0. Output enable is active whenever reset is not.
- R2: While reset is active, `dout_en` is 0 and `ceo_n` is 1 in the same cycle. Every rising clock edge taken under reset sets the address counter to 0.
- R3: While `ce_n` is 1, `dout_en` is 0 and `ceo_n` is 1, and rising edges leave the address counter unchanged.
- R4: A rising edge advances the address by one only when `ce_n` is 0, reset is inactive and the address is below `DEPTH`.
- R5: After each edge, `dout` holds the stored bit at the new address. Bits are read in address order from 0. The bit at address a is the XOR of the low 16 bits of (a*13 + `SEED`).
- R6: After `DEPTH` advancing edges, the address sits at `DEPTH`. In that state `dout_en` is 0, `ceo_n` is 0 while `ce_n` is 0 and output enable is active, and further edges do not move the counter.
- R7: Once past the last bit, `ceo_n` follows `ce_n` while output enable stays active. It goes to 1 as soon as reset becomes active and stays 1 until a read runs through all bits again.
- R8: When no reset is applied, raising `ce_n` in the middle of a read and lowering it later resumes the stream at the next unread bit, with no bit lost or repeated.
- R9: `dout_en` and a low `ceo_n` are never active together. When the cascade output drives the next device's chip enable, the shared line carries the first image followed directly by the second, with no gap cycle and no overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock supplied by the consumer; rising edge advances |
| rst_oe | input | 1 | Combined reset / output enable; polarity set by `RST_HIGH` |
| ce_n | input | 1 | Active-low chip enable |
| dout | output | 1 | Serial data bit (meaningful only when `dout_en` is 1) |
| dout_en | output | 1 | Drive enable for the shared data line |
| ceo_n | output | 1 | Active-low cascade output to the next device's `ce_n` |

## Verification
A wrong address shows on `dout` at the next sample after the edge that produced it. A skipped or repeated step moves every later bit by one position against the computed image. A counter that stops early or runs past the end shows on `dout_en` and `ceo_n` in the very cycle it should have handed over: the chained stream gets a silent gap, or both devices drive at once. A resume point lost during a chip-enable pause shows on the first bit after `ce_n` falls again.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  // Stored image content: parity of the low 16 bits of (addr*13 + seed).
  function automatic logic image_bit(input int unsigned addr, input int unsigned seed);
    logic [31:0] mix;
    mix = addr * 32'd13 + seed;
    return ^mix[15:0];
  endfunction

endpackage

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_nxt,
  output logic          past_tc
);
  localparam logic [AW-1:0] TC = AW'(DEPTH);

  always_comb begin
    if (clr)
      addr_nxt = '0;
    else if (adv && (addr_q != TC))
      addr_nxt = addr_q + 1'b1;
    else
      addr_nxt = addr_q;
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_nxt;
  end

  assign past_tc = (addr_q == TC);

endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int DEPTH = 1024,
  parameter int SEED  = 0,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic          dout_q
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] TC = AW'(DEPTH);

  logic          mem [DEPTH];
  logic [IW-1:0] rd_idx;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = serial_cfg_pkg::image_bit(i, SEED);
  end

  // The past-the-end address reads a harmless in-range cell.
  assign rd_idx = (rd_addr == TC) ? '0 : rd_addr[IW-1:0];

  always_ff @(posedge clk) begin
    dout_q <= mem[rd_idx];
  end

endmodule

// File: rtl/cfg_pin_ctrl.sv
module cfg_pin_ctrl #(
  parameter bit RST_HIGH = 1'b1
) (
  input  logic rst_oe,
  input  logic ce_n,
  input  logic past_tc,
  output logic rst_act,
  output logic dout_en,
  output logic ceo_n
);
  generate
    if (RST_HIGH) begin : g_rst_high
      assign rst_act = rst_oe;
    end else begin : g_rst_low
      assign rst_act = ~rst_oe;
    end
  endgenerate

  logic selected;
  assign selected = ~rst_act & ~ce_n;

  assign dout_en = selected & ~past_tc;
  assign ceo_n   = ~(selected & past_tc);

endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int DEPTH    = 1024,
  parameter int SEED     = 0,
  parameter bit RST_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_oe,
  input  logic ce_n,
  output logic dout,
  output logic dout_en,
  output logic ceo_n
);
  localparam int AW = $clog2(DEPTH + 1);

  logic          rst_act;
  logic          past_tc;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nxt;

  cfg_pin_ctrl #(.RST_HIGH(RST_HIGH)) u_pins (
    .rst_oe  (rst_oe),
    .ce_n    (ce_n),
    .past_tc (past_tc),
    .rst_act (rst_act),
    .dout_en (dout_en),
    .ceo_n   (ceo_n)
  );

  cfg_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk      (clk),
    .clr      (rst_act),
    .adv      (~ce_n),
    .addr_q   (addr_q),
    .addr_nxt (addr_nxt),
    .past_tc  (past_tc)
  );

  cfg_bit_store #(.DEPTH(DEPTH), .SEED(SEED), .AW(AW)) u_store (
    .clk     (clk),
    .rd_addr (addr_nxt),
    .dout_q  (dout)
  );

endmodule

// File: rtl/serial_cfg_rom_chk.sv
module serial_cfg_rom_chk #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_act,
  input logic          ce_n,
  input logic [AW-1:0] addr_q,
  input logic          dout_en,
  input logic          ceo_n
);
  localparam logic [AW-1:0] TC = AW'(DEPTH);

  logic seen_rst = 1'b0;
  always_ff @(posedge clk) begin
    if (rst_act) seen_rst <= 1'b1;
  end

  assert_rst_zero_R2: assert property (@(posedge clk) disable iff (!seen_rst)
    rst_act |=> (addr_q == '0));

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!seen_rst || rst_act)
    ce_n |=> $stable(addr_q));

  assert_step_R4: assert property (@(posedge clk) disable iff (!seen_rst || rst_act)
    (!ce_n && addr_q != TC) |=> (addr_q == $past(addr_q) + 1'b1));

  assert_hold_tc_R6: assert property (@(posedge clk) disable iff (!seen_rst || rst_act)
    (addr_q == TC) |=> (addr_q == TC));

  assert_bound_R6: assert property (@(posedge clk) disable iff (!seen_rst)
    addr_q <= TC);

  assert_handoff_R9: assert property (@(posedge clk) disable iff (!seen_rst)
    dout_en |-> ceo_n);

endmodule

bind serial_cfg_rom serial_cfg_rom_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_act (rst_act),
  .ce_n    (ce_n),
  .addr_q  (addr_q),
  .dout_en (dout_en),
  .ceo_n   (ceo_n)
);

// File: tb/serial_cfg_rom_tb.sv
module serial_cfg_rom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D0 = 40;
  localparam int S0 = 5;
  localparam int DA = 24;
  localparam int SA = 9;
  localparam int DB = 16;
  localparam int SB = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // single device, active-high reset
  logic rst_hi = 1'b1;
  logic ce0_n  = 1'b1;
  logic d0, d0_en, ceo0_n;

  serial_cfg_rom #(.DEPTH(D0), .SEED(S0), .RST_HIGH(1'b1)) u_dut (
    .clk(clk), .rst_oe(rst_hi), .ce_n(ce0_n),
    .dout(d0), .dout_en(d0_en), .ceo_n(ceo0_n)
  );

  // two-device chain, active-low reset
  logic rst_n    = 1'b0;
  logic chain_ce_n = 1'b1;
  logic da, da_en, ceoa_n, db, db_en, ceob_n;

  serial_cfg_rom #(.DEPTH(DA), .SEED(SA), .RST_HIGH(1'b0)) u_chain_a (
    .clk(clk), .rst_oe(rst_n), .ce_n(chain_ce_n),
    .dout(da), .dout_en(da_en), .ceo_n(ceoa_n)
  );

  serial_cfg_rom #(.DEPTH(DB), .SEED(SB), .RST_HIGH(1'b0)) u_chain_b (
    .clk(clk), .rst_oe(rst_n), .ce_n(ceoa_n),
    .dout(db), .dout_en(db_en), .ceo_n(ceob_n)
  );

  logic line;
  assign line = da_en ? da : (db_en ? db : 1'b1);

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  function automatic int ref_bit(input int a, input int seed);
    logic [15:0] v;
    v = 16'(a * 13 + seed);
    return int'(^v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  initial begin
    // ---------------- single device ----------------
    rst_hi = 1'b1; ce0_n = 1'b0;
    nxt(); nxt();
    chk(d0_en == 1'b0, "R1/R2 reset drive", int'(d0_en), 0);
    chk(ceo0_n == 1'b1, "R2 reset ceo", int'(ceo0_n), 1);
    rst_hi = 1'b0; #1;
    for (int k = 0; k < D0; k++) begin
      chk(d0_en == 1'b1, "R4 drive during read", int'(d0_en), 1);
      chk(int'(d0) == ref_bit(k, S0), "R5 data bit", int'(d0), ref_bit(k, S0));
      chk(ceo0_n == 1'b1, "R9 ceo high while reading", int'(ceo0_n), 1);
      nxt();
    end
    chk(d0_en == 1'b0, "R6 released after last bit", int'(d0_en), 0);
    chk(ceo0_n == 1'b0, "R6 ceo low after last bit", int'(ceo0_n), 0);
    nxt(); nxt();
    chk(d0_en == 1'b0 && ceo0_n == 1'b0, "R6 stays past end", int'({d0_en, ceo0_n}), 0);
    ce0_n = 1'b1; #1;
    chk(ceo0_n == 1'b1, "R7 ceo follows ce high", int'(ceo0_n), 1);
    nxt(); nxt();
    ce0_n = 1'b0; #1;
    chk(ceo0_n == 1'b0, "R7 ceo follows ce low", int'(ceo0_n), 0);
    chk(d0_en == 1'b0, "R3 no restart without reset", int'(d0_en), 0);
    rst_hi = 1'b1; #1;
    chk(ceo0_n == 1'b1, "R7 ceo high on reset", int'(ceo0_n), 1);
    chk(d0_en == 1'b0, "R2 no drive in reset", int'(d0_en), 0);
    nxt();
    rst_hi = 1'b0; #1;
    chk(int'(d0) == ref_bit(0, S0) && d0_en, "R2 restart at address 0", int'(d0), ref_bit(0, S0));
    chk(ceo0_n == 1'b1, "R7 ceo stays high after reset", int'(ceo0_n), 1);
    // pause in the middle: read bits 0..9, hold, resume
    for (int k = 0; k < 10; k++) begin
      chk(int'(d0) == ref_bit(k, S0), "R5 data before pause", int'(d0), ref_bit(k, S0));
      nxt();
    end
    ce0_n = 1'b1; #1;
    for (int k = 0; k < 5; k++) begin
      chk(d0_en == 1'b0 && ceo0_n == 1'b1, "R3 disabled state", int'({d0_en, ceo0_n}), 1);
      nxt();
    end
    ce0_n = 1'b0; #1;
    for (int k = 10; k < D0; k++) begin
      chk(d0_en && int'(d0) == ref_bit(k, S0), "R8 resume bit", int'(d0), ref_bit(k, S0));
      nxt();
    end
    chk(ceo0_n == 1'b0 && d0_en == 1'b0, "R8 end after resume", int'({d0_en, ceo0_n}), 0);

    // ---------------- chain, active-low reset ----------------
    rst_n = 1'b0; chain_ce_n = 1'b0;
    nxt(); nxt();
    chk(!da_en && !db_en, "R1 low-polarity reset no drive", int'({da_en, db_en}), 0);
    chk(ceoa_n == 1'b1, "R1 low-polarity ceo", int'(ceoa_n), 1);
    rst_n = 1'b1; #1;
    for (int k = 0; k < DA + DB; k++) begin
      int exp;
      exp = (k < DA) ? ref_bit(k, SA) : ref_bit(k - DA, SB);
      chk(!(da_en && db_en), "R9 no overlap", int'({da_en, db_en}), 1);
      chk(da_en ^ db_en, "R9 no gap", int'({da_en, db_en}), (k < DA) ? 2 : 1);
      chk(int'(line) == exp, "R9 chained stream", int'(line), exp);
      nxt();
    end
    chk(!da_en && !db_en, "R9 chain released", int'({da_en, db_en}), 0);
    chk(ceob_n == 1'b0, "R9 chain cascade out", int'(ceob_n), 0);
    rst_n = 1'b0; #1;
    chk(ceoa_n && ceob_n, "R7 chain reset raises ceo", int'({ceoa_n, ceob_n}), 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule